// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. A format byte picks the word length (5 to 8 bits), the stop length (one bit, or an extended stop of 1.5 bits for 5-bit words and 2 bits otherwise), and the parity mode (none, odd, even, or a parity bit forced to a fixed level). A separate break bit in the same byte holds the line at the spacing level for as long as it is set.

Characters arrive on a valid/ready handshake. The block accepts a character only when the line is idle. It captures the format byte in the same cycle, so later changes to the format do not alter the frame in progress. The break bit is the one exception and acts at once. Bit timing comes from a one-cycle enable pulse at 16 times the bit rate, produced outside the block. The serial output and the empty flag come straight from registers.

Top module: `uart_tx_framer`

## Requirements
- R1: Format bits [1:0] set the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R2: With format bit 2 at 0 the stop period is 16 ticks at logic 1. With bit 2 at 1 it is 24 ticks for a 5-bit word and 32 ticks for 6, 7 or 8-bit words.
- R3: With format bit 3 at 0 no parity bit is sent, whatever bits 4 and 5 hold. The stop period follows the last data bit directly.
- R4: With bits 3 at 1 and 5 at 0, the parity bit follows the data bits. Bit 4 at 0 makes the total count of ones in data plus parity odd, and bit 4 at 1 makes it even.
- R5: With bits 3 and 5 both at 1, the parity bit is 1 when bit 4 is 0 and 0 when bit 4 is 1, whatever the data.
- R6: While format bit 6 is 1, `txd` is 0 from the next clock edge on, whatever the shifter holds. Frame timing keeps running underneath, and the line returns to the frame's level once bit 6 clears.
- R7: The idle line is 1. A frame is a start bit of 0, then the data bits least significant first, then parity if enabled, then the stop period. Each non-stop bit lasts 16 ticks counted from the cycle after acceptance.
- R8: The format byte is captured when a character is accepted. Changes to bits 0 to 5 during the frame have no effect on that frame.
- R9: `in_ready` is 1 only while no frame is in progress. A character is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 0 from that edge on.
- R10: `tx_empty` falls on the accepting edge and rises, together with `in_ready`, on the edge that consumes the final tick of the stop period.
- R11: Data bits above the selected word length are never sent and do not affect parity.
- R12: After reset, `txd`, `tx_empty` and `in_ready` are all 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| in_valid | input | 1 | Character offered |
| in_data | input | DATA_W | Character to send, LSB first |
| line_ctl | input | CTL_W | Format byte: [1:0] length, 2 stop, 3 parity on, 4 even/forced level, 5 forced parity, 6 break |
| in_ready | output | 1 | Block can accept a character |
| txd | output | 1 | Serial line, idle high |
| tx_empty | output | 1 | No frame in progress |

## Verification
The assertions assume that `in_valid` is low while reset is asserted. The start-bit property assumes that a start bit lasts longer than one cycle, which holds because it needs 16 ticks. The bench offers a character only after it has seen `in_ready` high, drops `in_valid` right after the accepting edge, and keeps ticks out of the acceptance cycle so that the tick count per bit can be predicted exactly. Random format bytes during a frame always keep bit 6 clear, except in the runs that deliberately pulse break inside a chosen bit.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // Bit positions inside the format byte; the decoder depends on them
  localparam int FMT_LEN_LSB  = 0;
  localparam int FMT_XSTOP    = 2;
  localparam int FMT_PAR_ON   = 3;
  localparam int FMT_PAR_SEL  = 4;
  localparam int FMT_PAR_FORCE = 5;
  localparam int FMT_BREAK    = 6;

  localparam int MIN_WORD = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [3:0] nbits;
    logic       par_on;
    logic       par_sel;
    logic       par_force;
    logic       xstop;
  } frame_cfg_t;

endpackage

// File: rtl/uart_tx_fmt_decode.sv
module uart_tx_fmt_decode
  import uart_tx_pkg::*;
(
  input  logic [5:0]  fmt,
  output frame_cfg_t  cfg
);
  always_comb begin
    cfg.nbits     = 4'(MIN_WORD) + {2'b00, fmt[FMT_LEN_LSB +: 2]};
    cfg.xstop     = fmt[FMT_XSTOP];
    cfg.par_on    = fmt[FMT_PAR_ON];
    cfg.par_sel   = fmt[FMT_PAR_SEL];
    cfg.par_force = fmt[FMT_PAR_FORCE];
  end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  frame_cfg_t        cfg,
  output logic              par_bit
);
  logic [DATA_W-1:0] mask;
  logic              ones_odd;

  // Keep only the bits that belong to the selected word length
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (cfg.nbits > 4'(i));
  end

  assign ones_odd = ^(data & mask);

  always_comb begin
    if (cfg.par_force)
      par_bit = ~cfg.par_sel;
    else if (cfg.par_sel)
      par_bit = ones_odd;
    else
      par_bit = ~ones_odd;
  end
endmodule

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  assign done = tick && (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  parameter int CTL_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CTL_W-1:0]  line_ctl,
  output logic              in_ready,
  output logic              txd,
  output logic              tx_empty
);
  localparam int CNT_W    = $clog2(2 * OVERSAMPLE + 1);
  localparam int BITCNT_W = $clog2(DATA_W) + 1;
  localparam logic [CNT_W-1:0] BIT_TICKS  = CNT_W'(OVERSAMPLE);
  localparam logic [CNT_W-1:0] HALF_TICKS = CNT_W'(OVERSAMPLE / 2);

  tx_state_e             state_q, state_d;
  frame_cfg_t            cfg_in, cfg_q;
  logic [DATA_W-1:0]     shreg_q;
  logic [BITCNT_W-1:0]   bitcnt_q;
  logic                  par_in, par_q;
  logic                  txd_q, empty_q;
  logic                  accept, bit_done, last_data, line_bit;
  logic [CNT_W-1:0]      limit, stop_ticks;
  logic                  ctl_unused;

  assign ctl_unused = ^line_ctl[CTL_W-1:FMT_BREAK+1];

  uart_tx_fmt_decode u_decode (
    .fmt (line_ctl[5:0]),
    .cfg (cfg_in)
  );

  uart_tx_parity #(.DATA_W(DATA_W)) u_parity (
    .data    (in_data),
    .cfg     (cfg_in),
    .par_bit (par_in)
  );

  // Stop period length from the captured format
  always_comb begin
    if (!cfg_q.xstop)
      stop_ticks = BIT_TICKS;
    else if (cfg_q.nbits == 4'(MIN_WORD))
      stop_ticks = BIT_TICKS + HALF_TICKS;
    else
      stop_ticks = BIT_TICKS + BIT_TICKS;
  end

  assign limit = (state_q == ST_STOP) ? stop_ticks : BIT_TICKS;

  uart_tx_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (bit_done || (state_q == ST_IDLE)),
    .tick  (baud_tick),
    .limit (limit),
    .done  (bit_done)
  );

  assign last_data = (bitcnt_q == BITCNT_W'(cfg_q.nbits - 4'd1));

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          state_d = ST_START;
          accept  = 1'b1;
        end
      end
      ST_START:  if (bit_done) state_d = ST_DATA;
      ST_DATA:   if (bit_done && last_data) state_d = cfg_q.par_on ? ST_PARITY : ST_STOP;
      ST_PARITY: if (bit_done) state_d = ST_STOP;
      ST_STOP:   if (bit_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_START:  line_bit = 1'b0;
      ST_DATA:   line_bit = shreg_q[0];
      ST_PARITY: line_bit = par_q;
      default:   line_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cfg_q    <= '0;
      shreg_q  <= '0;
      bitcnt_q <= '0;
      par_q    <= 1'b0;
      txd_q    <= 1'b1;
      empty_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      empty_q <= (state_d == ST_IDLE);
      txd_q   <= line_ctl[FMT_BREAK] ? 1'b0 : line_bit;
      if (accept) begin
        cfg_q    <= cfg_in;
        shreg_q  <= in_data;
        par_q    <= par_in;
        bitcnt_q <= '0;
      end else if (state_q == ST_DATA && bit_done) begin
        shreg_q  <= {1'b0, shreg_q[DATA_W-1:1]};
        bitcnt_q <= bitcnt_q + BITCNT_W'(1);
      end
    end
  end

  assign in_ready = empty_q;
  assign tx_empty = empty_q;
  assign txd      = txd_q;

endmodule

// File: rtl/uart_tx_framer_sva.sv
module uart_tx_framer_sva #(
  parameter int CTL_W   = 8,
  parameter int BRK_BIT = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             txd,
  input logic             tx_empty,
  input logic [CTL_W-1:0] line_ctl
);
  // R6: break pulls the line low on the next edge
  a_r6_break_low: assert property (@(posedge clk) disable iff (rst)
    line_ctl[BRK_BIT] |=> !txd);

  // R7: an idle line without break sits at mark
  a_r7_idle_mark: assert property (@(posedge clk) disable iff (rst)
    tx_empty && !line_ctl[BRK_BIT] |=> txd);

  // R7: the start bit appears two edges after acceptance
  a_r7_start_space: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && in_ready, 2) && !$past(line_ctl[BRK_BIT]) |-> !txd);

  // R9: acceptance closes the handshake and ends the empty state
  a_r9_ready_drops: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> !in_ready && !tx_empty);

  // R10: with nothing offered an empty transmitter stays empty
  a_r10_empty_holds: assert property (@(posedge clk) disable iff (rst)
    tx_empty && !in_valid |=> tx_empty);

  // R12: reset leaves an idle, ready line
  a_r12_reset_idle: assert property (@(posedge clk)
    rst |=> tx_empty && in_ready && txd);
endmodule

bind uart_tx_framer uart_tx_framer_sva #(.CTL_W(CTL_W)) u_sva (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .txd      (txd),
  .tx_empty (tx_empty),
  .line_ctl (line_ctl)
);

// File: tb/uart_tx_framer_tb.sv
module uart_tx_framer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [7:0] line_ctl = 8'h00;
  logic       in_ready, txd, tx_empty;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;

  uart_tx_framer u_dut (
    .clk       (clk),
    .rst       (rst),
    .baud_tick (baud_tick),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .line_ctl  (line_ctl),
    .in_ready  (in_ready),
    .txd       (txd),
    .tx_empty  (tx_empty)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // One tick pulse, then two quiet cycles so registered outputs settle
  task automatic tick();
    @(negedge clk) baud_tick = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic par_exp(logic [7:0] d, logic [7:0] c);
    int   wl = 5 + int'(c[1:0]);
    logic p  = 1'b0;
    for (int i = 0; i < wl; i++) p ^= d[i];
    if (c[5]) return ~c[4];
    return c[4] ? p : ~p;
  endfunction

  // brk_k: index of the frame bit (0 = start) during which break is pulsed, -1 for none
  task automatic send_frame(input logic [7:0] d, input logic [7:0] c, input int brk_k);
    int          wl, pe, st, s_end, k, off, m;
    logic [15:0] bits;
    string       tag;
    wl = 5 + int'(c[1:0]);
    pe = int'(c[3]);
    st = c[2] ? ((wl == 5) ? 24 : 32) : 16;
    bits = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < wl; i++) bits[1+i] = d[i];
    if (pe != 0) bits[1+wl] = par_exp(d, c);
    s_end = 16 * (1 + wl + pe);

    @(negedge clk);
    chk(in_ready, 1'b1, "R9 ready before offer");
    in_data  = d;
    line_ctl = c & 8'hBF;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready, 1'b0, "R9 ready after accept");
    chk(tx_empty, 1'b0, "R10 empty after accept");
    in_data  = 8'($urandom);
    line_ctl = 8'($urandom) & 8'hBF;   // R8: format changes mid-frame

    for (int n = 1; n <= s_end + st; n++) begin
      tick();
      if (n <= s_end) begin
        k   = (n - 1) / 16;
        off = n - 16 * k;
        if (k == brk_k && off == 2)  line_ctl[6] = 1'b1;
        if (k == brk_k && off == 10) line_ctl[6] = 1'b0;
        if (k == 0)        tag = "R7 start bit";
        else if (k <= wl)  tag = "R1/R8 data bit";
        else if (c[5])     tag = "R5 forced parity";
        else               tag = "R4 parity bit";
        if (off == 8) begin
          if (k == brk_k) chk(txd, 1'b0, "R6 break in frame");
          else            chk(txd, bits[k], tag);
        end
        if (off == 14 && k == brk_k) chk(txd, bits[k], "R6 release restores frame");
        if (off == 8 && k == 1) chk(in_ready, 1'b0, "R9 busy during data");
      end else begin
        m = n - s_end;
        if (m == 8)      chk(txd, 1'b1, (pe != 0) ? "R2 stop start" : "R3/R11 stop after data");
        if (m == st - 4) chk(txd, 1'b1, "R2 stop end");
        if (m == st - 1) chk(tx_empty, 1'b0, "R2/R10 stop not yet done");
      end
    end
    chk(tx_empty, 1'b1, "R10 empty after stop");
    chk(in_ready, 1'b1, "R10 ready after stop");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4721));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd,      1'b1, "R12 txd after reset");
    chk(tx_empty, 1'b1, "R12 empty after reset");
    chk(in_ready, 1'b1, "R12 ready after reset");

    // R6 break while idle
    line_ctl = 8'h40;
    @(negedge clk);
    @(negedge clk);
    chk(txd, 1'b0, "R6 break while idle");
    chk(tx_empty, 1'b1, "R6 break leaves empty");
    line_ctl = 8'h00;
    @(negedge clk);
    @(negedge clk);
    chk(txd, 1'b1, "R6 break released");

    // R1/R2/R3: every length and stop choice, parity off with junk in bits 4-5
    for (int c3 = 0; c3 < 8; c3++)
      send_frame(8'h35, 8'(c3) | 8'h30 & 8'h37, -1);

    // R4/R5: every parity mode at 8 bits
    for (int pm = 0; pm < 4; pm++) begin
      send_frame(8'h00, 8'h0B | 8'(pm << 4), -1);
      send_frame(8'hFF, 8'h0B | 8'(pm << 4), -1);
      send_frame(8'h6B, 8'h0B | 8'(pm << 4), -1);
    end

    // R11: upper bits must be neither sent nor counted in parity
    send_frame(8'hE0, 8'h00, -1);
    send_frame(8'hE0, 8'h08, -1);
    send_frame(8'hC0, 8'h19, -1);

    // R6: break pulsed inside a data bit of a running frame
    send_frame(8'hFF, 8'h03, 3);

    for (int r = 0; r < 50; r++) begin
      logic [7:0] d, c;
      int         bk;
      d  = 8'($urandom);
      c  = 8'($urandom) & 8'h3F;
      bk = ($urandom % 4 == 0) ? int'($urandom % 6) : -1;
      send_frame(d, c, bk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule